// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block runs one external memory or I/O transfer at a time over a narrow port that is shared between address and data. A request gives a 16-bit address, a direction, a write byte, a memory-space flag and a stretch flag. The block then drives the low address byte on the shared port and the high byte on a dedicated port. It pulses an active-low address strobe, releases the shared port, and holds an active-low data strobe low for a time that depends on the direction. It returns the byte sampled at the end of a read strobe.

The clock of the block is the phase-tick clock, which runs at twice the bus reference rate, so one clock cycle is half a reference period. Every strobe width and gap is a whole number of these cycles. For the external port the bus is modelled as separate output, enable and input vectors, and the pad ring combines them. When the stretch flag is set, the data strobe is held low for two more reference periods on reads and on writes.

Top module: `mux_bus_master`

## Requirements
- R1: While no transfer is in progress, `as_n`, `ds_n`, `rw_n` and `dm_n` are 1 and `ad_oe`, `busy` and `done` are 0.
- R2: A request with `req_valid` high while `busy` is low is accepted at that clock edge. In the next cycle, `ad_out` carries `req_addr[7:0]` with `ad_oe` = 1, `addr_hi` carries `req_addr[15:8]`, and `as_n` is still 1. In the cycle after that, `as_n` is 0 for exactly one cycle and the same address is still driven.
- R3: In the cycle after `as_n` returns to 1, `ds_n` stays 1 and the low address is no longer on the port. On a read, `ad_oe` is 0 from that cycle until the transfer ends. `ds_n` falls in the following cycle.
- R4: On a read without stretch, `ds_n` is low for exactly 5 cycles.
- R5: On a write without stretch, `ds_n` is low for exactly 3 cycles. `ad_out` carries `req_wdata` with `ad_oe` = 1 from the cycle after `as_n` rises through the cycle after `ds_n` rises.
- R6: When `req_ext` is 1 at acceptance, the `ds_n` low time is 4 cycles longer: 9 for a read and 7 for a write.
- R7: `rw_n` (0 = write, 1 = read) and `dm_n` (0 when `req_dmem` = 1) hold their values from the cycle after acceptance through the cycle after `ds_n` rises.
- R8: `done` is high for exactly one cycle, the cycle after `ds_n` rises. After a read, `rdata` in that cycle equals the `ad_in` value present in the last `ds_n`-low cycle. A write leaves `rdata` unchanged.
- R9: `busy` is 1 from the cycle after acceptance through the `done` cycle. Requests presented while `busy` is 1 are ignored. The earliest next `as_n` fall comes at least 2 cycles after `ds_n` rises.
- R10: A synchronous reset (`rst` = 1) at any point of a transfer leaves, from the next cycle on, both strobes at 1, `ad_oe`, `busy` and `done` at 0, and `rdata` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-tick clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Byte to write |
| req_dmem | input | 1 | Selects data memory space |
| req_ext | input | 1 | Stretch the data strobe by 4 ticks |
| busy | output | 1 | Transfer in progress, requests ignored |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdata | output | 8 | Last byte read |
| ad_out | output | 8 | Shared port output value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input value |
| addr_hi | output | 8 | High address byte port |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw_n | output | 1 | Read (1) / write (0) select |
| dm_n | output | 1 | Data memory select, active low |

## Verification
Two functions can fall in the same cycle. At the edge where the data strobe rises, the read byte is captured and a new request may be arriving. In the recovery cycle, `done` is reported while `req_valid` may already be high. The bench keeps `req_valid` high with random fields through every busy cycle, including the `done` cycle, and starts the next transfer in the very first idle cycle. This shows that the stray requests leave the address, the select lines and the captured byte unchanged. It also drives a new random `ad_in` every cycle, so a capture taken one cycle early or late produces a wrong `rdata`.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_ASTB  = 3'd2,
    ST_FLOAT = 3'd3,
    ST_DSTB  = 3'd4,
    ST_RECOV = 3'd5
  } bus_state_t;

  // Data strobe low time in phase ticks for one transfer.
  function automatic int unsigned strobe_ticks(input logic wr, input logic ext,
                                               input int unsigned rd_t,
                                               input int unsigned wr_t,
                                               input int unsigned ext_t);
    int unsigned t;
    t = wr ? wr_t : rd_t;
    if (ext) t = t + ext_t;
    return t;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mbus_req_latch.sv
module mbus_req_latch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic              in_write,
  input  logic              in_dmem,
  input  logic              in_ext,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] port_in,
  output logic              lat_write,
  output logic              lat_dmem,
  output logic              lat_ext,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] lat_wdata,
  output logic [DATA_W-1:0] rd_byte
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_write <= 1'b0;
      lat_dmem  <= 1'b0;
      lat_ext   <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else if (accept) begin
      lat_write <= in_write;
      lat_dmem  <= in_dmem;
      lat_ext   <= in_ext;
      lat_addr  <= in_addr;
      lat_wdata <= in_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_byte <= '0;
    else if (capture) rd_byte <= port_in;
  end

  // The read byte only changes on a capture (R8).
  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(capture) && !$past(rst) |-> $stable(rd_byte));

  // A read capture never coincides with taking a new request (R9).
  assert_no_accept_on_capture_R9: assert property (@(posedge clk) disable iff (rst)
    !(accept && capture));

endmodule

// File: rtl/mbus_strobe_timer.sv
module mbus_strobe_timer
  import mbus_pkg::*;
#(
  parameter int unsigned RD_TICKS  = 5,
  parameter int unsigned WR_TICKS  = 3,
  parameter int unsigned EXT_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  input  logic wr,
  input  logic ext,
  output logic last
);

  localparam int unsigned MAX_TICKS = max_u(RD_TICKS, WR_TICKS) + EXT_TICKS;
  localparam int          CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    load_val = CNT_W'(strobe_ticks(wr, ext, RD_TICKS, WR_TICKS, EXT_TICKS) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst)                       cnt <= '0;
    else if (load)                 cnt <= load_val;
    else if (run && (cnt != '0))   cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);

  // The counter never exceeds the longest strobe (R6).
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) < int'(MAX_TICKS));

  // While running, the count falls by one each cycle (R4).
  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (rst)
    run && !last && !load |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/mbus_sequencer.sv
module mbus_sequencer
  import mbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       wr,
  input  logic       timer_last,
  output bus_state_t state,
  output logic       accept,
  output logic       timer_load,
  output logic       timer_run,
  output logic       capture
);

  bus_state_t state_d;

  always_comb begin
    state_d    = state;
    accept     = 1'b0;
    timer_load = 1'b0;
    timer_run  = 1'b0;
    capture    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_ADDR;
        end
      end
      ST_ADDR:  state_d = ST_ASTB;
      ST_ASTB:  state_d = ST_FLOAT;
      ST_FLOAT: begin
        timer_load = 1'b1;
        state_d    = ST_DSTB;
      end
      ST_DSTB: begin
        timer_run = 1'b1;
        if (timer_last) begin
          capture = !wr;
          state_d = ST_RECOV;
        end
      end
      ST_RECOV: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_d;
  end

  // Address strobe phase lasts one tick and is followed by the float tick (R2, R3).
  assert_astb_then_float_R3: assert property (@(posedge clk) disable iff (rst)
    state == ST_ASTB |=> state == ST_FLOAT);

  // Recovery always returns to idle (R9).
  assert_recov_then_idle_R9: assert property (@(posedge clk) disable iff (rst)
    state == ST_RECOV |=> state == ST_IDLE);

endmodule

// File: rtl/mbus_pad_drive.sv
module mbus_pad_drive
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  bus_state_t        state,
  input  logic              wr,
  input  logic              dmem,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic              as_n,
  output logic              ds_n,
  output logic              rw_n,
  output logic              dm_n
);

  logic addr_phase;
  logic data_phase;
  logic active;

  always_comb begin
    active     = (state != ST_IDLE);
    addr_phase = (state == ST_ADDR) || (state == ST_ASTB);
    data_phase = (state == ST_FLOAT) || (state == ST_DSTB) || (state == ST_RECOV);
    as_n       = (state != ST_ASTB);
    ds_n       = (state != ST_DSTB);
    rw_n       = active ? !wr   : 1'b1;
    dm_n       = active ? !dmem : 1'b1;
    ad_oe      = addr_phase || (wr && data_phase);
    ad_out     = addr_phase ? addr[DATA_W-1:0] : wdata;
    addr_hi    = addr[ADDR_W-1:DATA_W];
  end

endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
  import mbus_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int unsigned RD_TICKS  = 5,
  parameter int unsigned WR_TICKS  = 3,
  parameter int unsigned EXT_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_dmem,
  input  logic              req_ext,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic              as_n,
  output logic              ds_n,
  output logic              rw_n,
  output logic              dm_n
);

  localparam int HI_W = ADDR_W - DATA_W;

  bus_state_t        state;
  logic              accept;
  logic              timer_load;
  logic              timer_run;
  logic              timer_last;
  logic              capture;
  logic              lat_write;
  logic              lat_dmem;
  logic              lat_ext;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;

  mbus_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .wr         (lat_write),
    .timer_last (timer_last),
    .state      (state),
    .accept     (accept),
    .timer_load (timer_load),
    .timer_run  (timer_run),
    .capture    (capture)
  );

  mbus_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .capture   (capture),
    .in_write  (req_write),
    .in_dmem   (req_dmem),
    .in_ext    (req_ext),
    .in_addr   (req_addr),
    .in_wdata  (req_wdata),
    .port_in   (ad_in),
    .lat_write (lat_write),
    .lat_dmem  (lat_dmem),
    .lat_ext   (lat_ext),
    .lat_addr  (lat_addr),
    .lat_wdata (lat_wdata),
    .rd_byte   (rdata)
  );

  mbus_strobe_timer #(.RD_TICKS(RD_TICKS), .WR_TICKS(WR_TICKS), .EXT_TICKS(EXT_TICKS)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (timer_load),
    .run  (timer_run),
    .wr   (lat_write),
    .ext  (lat_ext),
    .last (timer_last)
  );

  mbus_pad_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pads (
    .state   (state),
    .wr      (lat_write),
    .dmem    (lat_dmem),
    .addr    (lat_addr),
    .wdata   (lat_wdata),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .addr_hi (addr_hi),
    .as_n    (as_n),
    .ds_n    (ds_n),
    .rw_n    (rw_n),
    .dm_n    (dm_n)
  );

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_RECOV);

  // Strobe width monitor feeding the length assertion below.
  logic [7:0] ds_len;
  always_ff @(posedge clk) begin
    if (rst)        ds_len <= '0;
    else if (!ds_n) ds_len <= ds_len + 8'd1;
    else            ds_len <= '0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> as_n && ds_n && rw_n && dm_n && !ad_oe && !done);

  assert_as_width_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(as_n) |=> as_n);

  assert_addr_at_as_R2: assert property (@(posedge clk) disable iff (rst)
    !as_n |-> ad_oe && $stable(ad_out) && $stable(addr_hi));

  assert_read_float_R3: assert property (@(posedge clk) disable iff (rst)
    !ds_n && rw_n |-> !ad_oe);

  assert_float_gap_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ds_n) |-> as_n && $past(as_n));

  // Covers R4 and R5 as well: width depends on direction and stretch.
  assert_ds_len_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ds_n) && !$past(rst) |->
      int'(ds_len) == int'(strobe_ticks(lat_write, lat_ext, RD_TICKS, WR_TICKS, EXT_TICKS)));

  assert_wdata_hold_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ds_n) && !rw_n && !$past(rst) |-> ad_oe && $stable(ad_out));

  assert_select_stable_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ds_n) && !$past(rst) |-> $stable(rw_n) && $stable(dm_n));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_ds_R8: assert property (@(posedge clk) disable iff (rst)
    done && !$past(rst) |-> $past(!ds_n) && ds_n);

  assert_busy_starts_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> !as_n);

  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (rst)
    busy && !done |=> busy);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> as_n && ds_n && !busy && !ad_oe && !done);

endmodule

// File: tb/tb_mux_bus_master.sv
`timescale 1ns/1ps
module tb_mux_bus_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_dmem = 1'b0;
  logic        req_ext = 1'b0;
  logic        busy, done;
  logic [7:0]  rdata, ad_out, addr_hi;
  logic        ad_oe, as_n, ds_n, rw_n, dm_n;
  logic [7:0]  ad_in = '0;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] rdata_model = '0;

  always #2.5 clk = ~clk;

  mux_bus_master dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_dmem(req_dmem),
    .req_ext(req_ext), .busy(busy), .done(done), .rdata(rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi),
    .as_n(as_n), .ds_n(ds_n), .rw_n(rw_n), .dm_n(dm_n)
  );

  function automatic int low_time(input bit wr, input bit ext);
    int base;
    base = 5;
    if (wr) base = 3;
    return ext ? base + 4 : base;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string req);
    check(req, "as_n idle", 32'(as_n), 1);
    check(req, "ds_n idle", 32'(ds_n), 1);
    check(req, "rw_n idle", 32'(rw_n), 1);
    check(req, "dm_n idle", 32'(dm_n), 1);
    check(req, "ad_oe idle", 32'(ad_oe), 0);
    check(req, "busy idle", 32'(busy), 0);
    check(req, "done idle", 32'(done), 0);
  endtask

  // Called at a falling edge with the block idle; returns at the falling edge of
  // the first idle cycle after the transfer.
  task automatic run_txn(input bit wr, input bit ext, input bit dm,
                         input logic [15:0] a, input logic [7:0] wd, input bit noise);
    int n;
    logic [7:0] exp_rd;
    n = low_time(wr, ext);
    exp_rd = rdata_model;
    req_valid = 1'b1; req_write = wr; req_ext = ext; req_dmem = dm;
    req_addr = a; req_wdata = wd; ad_in = 8'($urandom);
    @(negedge clk);
    for (int k = 1; k <= 4 + n; k++) begin
      check("R2", "as_n", 32'(as_n), (k == 2) ? 0 : 1);
      check("R4", "ds_n", 32'(ds_n), (k >= 4 && k <= 3 + n) ? 0 : 1);
      if (k == 4 + n) check("R6", "ds_n high after width", 32'(ds_n), 1);
      check("R3", "ad_oe", 32'(ad_oe), (k <= 2 || wr) ? 1 : 0);
      if (k <= 2)  check("R2", "low address", 32'(ad_out), 32'(a[7:0]));
      else if (wr) check("R5", "write data", 32'(ad_out), 32'(wd));
      check("R2", "addr_hi", 32'(addr_hi), 32'(a[15:8]));
      check("R7", "rw_n", 32'(rw_n), wr ? 0 : 1);
      check("R7", "dm_n", 32'(dm_n), dm ? 0 : 1);
      check("R9", "busy", 32'(busy), 1);
      check("R8", "done", 32'(done), (k == 4 + n) ? 1 : 0);
      if (k == 4 + n) check("R8", "rdata", 32'(rdata), 32'(exp_rd));
      ad_in = 8'($urandom);
      if (!wr && k == 3 + n) exp_rd = ad_in;
      if (noise && k < 4 + n) begin
        req_valid = 1'b1; req_write = 1'($urandom); req_ext = 1'($urandom);
        req_dmem = 1'($urandom); req_addr = 16'($urandom); req_wdata = 8'($urandom);
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    rdata_model = exp_rd;
    check_idle("R9");
  endtask

  task automatic reset_mid(input bit wr, input int stop_k);
    req_valid = 1'b1; req_write = wr; req_ext = 1'b1; req_dmem = 1'b1;
    req_addr = 16'($urandom); req_wdata = 8'($urandom);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (stop_k - 1) @(negedge clk);
    check("R10", "strobe active before reset", 32'(ds_n & as_n), 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rdata_model = '0;
    check_idle("R10");
    check("R10", "rdata cleared", 32'(rdata), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check_idle("R10");
    rst = 1'b0;
    @(negedge clk);
    repeat (3) @(negedge clk);
    check_idle("R1");
    // Directed corners
    run_txn(1'b0, 1'b0, 1'b0, 16'hA55A, 8'h00, 1'b0); // R4 plain read
    run_txn(1'b1, 1'b0, 1'b1, 16'h1234, 8'hC3, 1'b0); // R5 plain write
    run_txn(1'b0, 1'b1, 1'b1, 16'hFF00, 8'h00, 1'b1); // R6 stretched read
    run_txn(1'b1, 1'b1, 1'b0, 16'h00FF, 8'h3C, 1'b1); // R6 stretched write
    run_txn(1'b1, 1'b0, 1'b0, 16'h8001, 8'hFF, 1'b1); // R8 write keeps rdata
    // Reset during the data strobe and during the address strobe (R10)
    reset_mid(1'b0, 5);
    reset_mid(1'b1, 2);
    @(negedge clk);
    check_idle("R1");
    // Random back-to-back traffic with stray requests while busy
    for (int i = 0; i < 60; i++) begin
      run_txn(1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
              8'($urandom), 1'($urandom));
    end
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    check_idle("R1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_fail++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule